// File: doc/BRIEF.md
# MMU System Control Register File

This block holds the software-visible control state of a memory management unit and turns maintenance writes into command pulses. A host reaches it through a register-number select, a write enable, a 32-bit write data bus and a combinational read data bus. Six registers are stored: control, translation table base, domain access, fault status, fault address and process identifier. Each register applies its own bit mask on write: some bits are forced to one, others forced to zero.

Three register numbers carry no storage. A write to one of them is a maintenance operation, selected by a 3-bit sub-opcode and a 4-bit secondary field (CRm) presented with the write. The block decodes the pair and, in the cycle after the write, raises a one-cycle pulse for caches, TLBs, write buffer or read buffer, with the write data on an address side output. The caches, TLBs and buffers are outside the block; they see only the pulses. A pair that names no operation raises an error pulse and changes nothing.

Top module: `mmu_sysreg_regfile`

## Requirements
- R1: After a clock edge with rst_n low, the control register reads 0x0000_0070 and the fault status, fault address, process identifier, table base and domain registers read zero.
- R2: Register numbers are: 1 control, 2 table base, 3 domain, 5 fault status, 6 fault address, 13 process identifier, 7 cache operations, 8 TLB operations, 9 read-buffer operations; rd_data shows the selected register combinationally, and every other number, including 7, 8 and 9, reads zero.
- R3: A control write stores (data OR 0x70) AND 0xFFFD: bits 6:4 read one, bit 1 and bits 31:16 read zero.
- R4: A table base write keeps bits 31:14; bits 13:0 read zero.
- R5: A fault status write keeps bits 7:0, a process identifier write keeps bits 30:25, and domain and fault address writes keep all 32 bits.
- R6: Register 7 with sub-opcode 0: CRm 7 pulses both inv_icache_o and inv_dcache_o, CRm 5 only inv_icache_o, CRm 6 only inv_dcache_o.
- R7: Register 7: sub-opcode 1 with CRm 6 pulses inv_dline_o, sub-opcode 1 with CRm 0xA pulses clean_dline_o, both with the write data on maint_addr_o; sub-opcode 4 with CRm 0xA pulses drain_wb_o.
- R8: Register 8 with sub-opcode 0: CRm 7 pulses inv_itlb_o and inv_dtlb_o, CRm 5 only inv_itlb_o, CRm 6 only inv_dtlb_o; sub-opcode 1 with CRm 6 pulses inv_dtlb_entry_o with the write data on maint_addr_o.
- R9: Register 9 with sub-opcode 2 and CRm[3:2] not 3 pulses rb_load_o, with rb_index_o = CRm[1:0], rb_type_o = CRm[3:2]+1 and the write data on maint_addr_o.
- R10: Register 9: sub-opcode 0 with CRm 0 pulses rb_inv_all_o; sub-opcode 1 with CRm below 4 pulses rb_inv_entry_o with rb_index_o = CRm[1:0].
- R11: Each command pulse and op_err_o is high for exactly the one cycle after the clock edge that samples the write, and is low after an edge with no maintenance write.
- R12: Any other pair on registers 7, 8 or 9 pulses op_err_o alone; no maintenance write changes a stored register, and a write to an unlisted number changes nothing and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 4 | Register number |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data or maintenance address |
| sub_op | input | 3 | Maintenance sub-opcode |
| crm | input | 4 | Maintenance secondary field |
| rd_data | output | 32 | Selected register value |
| ctrl_o | output | 32 | Control register |
| ttb_o | output | 32 | Translation table base |
| dac_o | output | 32 | Domain access register |
| pid_o | output | 32 | Process identifier |
| inv_icache_o | output | 1 | Invalidate instruction cache |
| inv_dcache_o | output | 1 | Invalidate data caches |
| inv_dline_o | output | 1 | Invalidate one data line |
| clean_dline_o | output | 1 | Clean one data line |
| drain_wb_o | output | 1 | Drain write buffer |
| inv_itlb_o | output | 1 | Invalidate instruction TLB |
| inv_dtlb_o | output | 1 | Invalidate data TLB |
| inv_dtlb_entry_o | output | 1 | Invalidate one data TLB entry |
| rb_load_o | output | 1 | Load read-buffer entry |
| rb_inv_entry_o | output | 1 | Invalidate one read-buffer entry |
| rb_inv_all_o | output | 1 | Invalidate all read-buffer entries |
| maint_addr_o | output | 32 | Address for line, entry and load commands |
| rb_index_o | output | 2 | Read-buffer entry index |
| rb_type_o | output | 2 | Read-buffer load type (1 to 3) |
| op_err_o | output | 1 | Unknown maintenance pair |

## Verification
A command pulse from one maintenance write occupies the same cycle in which the host may already present the next write, so pulse output and a register update can overlap. The bench issues a cache invalidate and, in the very next cycle, a control write, then checks that the pulse is present while the control write is on the bus, that it is gone one edge later, and that the control value has then taken the masked data. Every pair of sub-opcode and CRm on all three maintenance numbers is swept, and after each the stored registers are read back against a bench model to show that the command path never disturbs storage.

// File: rtl/mmu_sysreg_pkg.sv
// Shared constants and types of the MMU system control register file.
// Assumes a 32-bit data path; register numbers are decoded by the host side.
package mmu_sysreg_pkg;

    localparam int DW   = 32;
    localparam int SELW = 4;
    localparam int SUBW = 3;
    localparam int CRMW = 4;
    localparam int NREG = 6;

    // register numbers
    localparam logic [SELW-1:0] SEL_CTRL  = 4'd1;
    localparam logic [SELW-1:0] SEL_TTB   = 4'd2;
    localparam logic [SELW-1:0] SEL_DAC   = 4'd3;
    localparam logic [SELW-1:0] SEL_FSR   = 4'd5;
    localparam logic [SELW-1:0] SEL_FAR   = 4'd6;
    localparam logic [SELW-1:0] SEL_CACHE = 4'd7;
    localparam logic [SELW-1:0] SEL_TLB   = 4'd8;
    localparam logic [SELW-1:0] SEL_RBUF  = 4'd9;
    localparam logic [SELW-1:0] SEL_PID   = 4'd13;

    // storage slots
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_TTB  = 1;
    localparam int SLOT_DAC  = 2;
    localparam int SLOT_FSR  = 3;
    localparam int SLOT_FAR  = 4;
    localparam int SLOT_PID  = 5;

    // sub-opcode and CRm codes
    localparam logic [SUBW-1:0] SUB_GLOBAL = 3'd0;
    localparam logic [SUBW-1:0] SUB_ENTRY  = 3'd1;
    localparam logic [SUBW-1:0] SUB_LOAD   = 3'd2;
    localparam logic [SUBW-1:0] SUB_DRAIN  = 3'd4;
    localparam logic [CRMW-1:0] CRM_ZERO   = 4'd0;
    localparam logic [CRMW-1:0] CRM_INSTR  = 4'd5;
    localparam logic [CRMW-1:0] CRM_DATA   = 4'd6;
    localparam logic [CRMW-1:0] CRM_BOTH   = 4'd7;
    localparam logic [CRMW-1:0] CRM_CLEAN  = 4'hA;

    typedef struct packed {
        logic inv_i;
        logic inv_d;
        logic line_inv;
        logic line_clean;
        logic drain;
        logic tlb_i;
        logic tlb_d;
        logic tlb_entry;
        logic rb_load;
        logic rb_inv_one;
        logic rb_inv_all;
        logic bad;
    } maint_t;

    function automatic logic [SELW-1:0] slot_sel(input int s);
        case (s)
            SLOT_CTRL: return SEL_CTRL;
            SLOT_TTB:  return SEL_TTB;
            SLOT_DAC:  return SEL_DAC;
            SLOT_FSR:  return SEL_FSR;
            SLOT_FAR:  return SEL_FAR;
            default:   return SEL_PID;
        endcase
    endfunction

    function automatic logic [DW-1:0] slot_force(input int s);
        return (s == SLOT_CTRL) ? 32'h0000_0070 : 32'h0;
    endfunction

    function automatic logic [DW-1:0] slot_keep(input int s);
        case (s)
            SLOT_CTRL: return 32'h0000_FFFD;
            SLOT_TTB:  return 32'hFFFF_C000;
            SLOT_FSR:  return 32'h0000_00FF;
            SLOT_PID:  return 32'h7E00_0000;
            default:   return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [DW-1:0] slot_reset(input int s);
        return (s == SLOT_CTRL) ? 32'h0000_0070 : 32'h0;
    endfunction

endpackage

// File: rtl/mmu_masked_reg.sv
// One stored register: on write, forces FORCE bits high and keeps only KEEP bits.
// Assumes FORCE is a subset of KEEP so forced bits are visible.
module mmu_masked_reg
    import mmu_sysreg_pkg::*;
#(
    parameter logic [DW-1:0] FORCE = '0,
    parameter logic [DW-1:0] KEEP  = '1,
    parameter logic [DW-1:0] RST   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);

    // masked storage update
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= RST;
        else if (we_i)
            q_o <= (d_i | FORCE) & KEEP;
    end

endmodule

// File: rtl/mmu_reg_bank.sv
// Bank of all stored registers plus the combinational read multiplexer.
// Assumes register numbers without a slot read as zero.
module mmu_reg_bank
    import mmu_sysreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [SELW-1:0]          sel_i,
    input  logic [DW-1:0]            wr_data_i,
    output logic [NREG-1:0][DW-1:0]  q_o,
    output logic [DW-1:0]            rd_data_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        mmu_masked_reg #(
            .FORCE (slot_force(g)),
            .KEEP  (slot_keep(g)),
            .RST   (slot_reset(g))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we_i  (wr_en_i && (sel_i == slot_sel(g))),
            .d_i   (wr_data_i),
            .q_o   (q_o[g])
        );
    end

    // read selection, zero for unmapped numbers
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel_i == slot_sel(i))
                rd_data_o = q_o[i];
        end
    end

endmodule

// File: rtl/mmu_maint_decode.sv
// Decodes maintenance writes (cache, TLB, read buffer) into registered
// one-cycle pulses with address and read-buffer side fields.
// Assumes side fields hold their last value between commands.
module mmu_maint_decode
    import mmu_sysreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] sel_i,
    input  logic [SUBW-1:0] sub_i,
    input  logic [CRMW-1:0] crm_i,
    input  logic [DW-1:0]   wr_data_i,
    output maint_t          cmd_o,
    output logic [DW-1:0]   addr_o,
    output logic [1:0]      rb_idx_o,
    output logic [1:0]      rb_type_o
);

    maint_t nxt;
    logic   low_crm;

    assign low_crm = (crm_i[3:2] == 2'b00);

    // pair decode for the current write
    always_comb begin
        nxt = '0;
        if (wr_en_i) begin
            case (sel_i)
                SEL_CACHE: begin
                    if (sub_i == SUB_GLOBAL && crm_i == CRM_BOTH) begin
                        nxt.inv_i = 1'b1;
                        nxt.inv_d = 1'b1;
                    end
                    else if (sub_i == SUB_GLOBAL && crm_i == CRM_INSTR) nxt.inv_i      = 1'b1;
                    else if (sub_i == SUB_GLOBAL && crm_i == CRM_DATA)  nxt.inv_d      = 1'b1;
                    else if (sub_i == SUB_ENTRY  && crm_i == CRM_DATA)  nxt.line_inv   = 1'b1;
                    else if (sub_i == SUB_ENTRY  && crm_i == CRM_CLEAN) nxt.line_clean = 1'b1;
                    else if (sub_i == SUB_DRAIN  && crm_i == CRM_CLEAN) nxt.drain      = 1'b1;
                    else                                                 nxt.bad        = 1'b1;
                end
                SEL_TLB: begin
                    if (sub_i == SUB_GLOBAL && crm_i == CRM_BOTH) begin
                        nxt.tlb_i = 1'b1;
                        nxt.tlb_d = 1'b1;
                    end
                    else if (sub_i == SUB_GLOBAL && crm_i == CRM_INSTR) nxt.tlb_i     = 1'b1;
                    else if (sub_i == SUB_GLOBAL && crm_i == CRM_DATA)  nxt.tlb_d     = 1'b1;
                    else if (sub_i == SUB_ENTRY  && crm_i == CRM_DATA)  nxt.tlb_entry = 1'b1;
                    else                                                 nxt.bad       = 1'b1;
                end
                SEL_RBUF: begin
                    if (sub_i == SUB_GLOBAL && crm_i == CRM_ZERO)         nxt.rb_inv_all = 1'b1;
                    else if (sub_i == SUB_LOAD && crm_i[3:2] != 2'b11)    nxt.rb_load    = 1'b1;
                    else if (sub_i == SUB_ENTRY && low_crm)               nxt.rb_inv_one = 1'b1;
                    else                                                   nxt.bad        = 1'b1;
                end
                default: nxt = '0;
            endcase
        end
    end

    // pulse and side-field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o     <= '0;
            addr_o    <= '0;
            rb_idx_o  <= '0;
            rb_type_o <= '0;
        end
        else begin
            cmd_o <= nxt;
            if (nxt.line_inv || nxt.line_clean || nxt.tlb_entry || nxt.rb_load)
                addr_o <= wr_data_i;
            if (nxt.rb_load || nxt.rb_inv_one)
                rb_idx_o <= crm_i[1:0];
            if (nxt.rb_load)
                rb_type_o <= crm_i[3:2] + 2'd1;
        end
    end

endmodule

// File: rtl/mmu_sysreg_regfile.sv
// Top of the MMU system control register file: masked storage registers,
// read multiplexer and maintenance command decode.
// Assumes a single host; reads are combinational, writes take one edge.
module mmu_sysreg_regfile
    import mmu_sysreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] reg_sel,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic [SUBW-1:0] sub_op,
    input  logic [CRMW-1:0] crm,
    output logic [DW-1:0]   rd_data,
    output logic [DW-1:0]   ctrl_o,
    output logic [DW-1:0]   ttb_o,
    output logic [DW-1:0]   dac_o,
    output logic [DW-1:0]   pid_o,
    output logic            inv_icache_o,
    output logic            inv_dcache_o,
    output logic            inv_dline_o,
    output logic            clean_dline_o,
    output logic            drain_wb_o,
    output logic            inv_itlb_o,
    output logic            inv_dtlb_o,
    output logic            inv_dtlb_entry_o,
    output logic            rb_load_o,
    output logic            rb_inv_entry_o,
    output logic            rb_inv_all_o,
    output logic [DW-1:0]   maint_addr_o,
    output logic [1:0]      rb_index_o,
    output logic [1:0]      rb_type_o,
    output logic            op_err_o
);

    logic [NREG-1:0][DW-1:0] regs;
    maint_t                  cmd;

    mmu_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .sel_i     (reg_sel),
        .wr_data_i (wr_data),
        .q_o       (regs),
        .rd_data_o (rd_data)
    );

    mmu_maint_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .sel_i     (reg_sel),
        .sub_i     (sub_op),
        .crm_i     (crm),
        .wr_data_i (wr_data),
        .cmd_o     (cmd),
        .addr_o    (maint_addr_o),
        .rb_idx_o  (rb_index_o),
        .rb_type_o (rb_type_o)
    );

    assign ctrl_o           = regs[SLOT_CTRL];
    assign ttb_o            = regs[SLOT_TTB];
    assign dac_o            = regs[SLOT_DAC];
    assign pid_o            = regs[SLOT_PID];
    assign inv_icache_o     = cmd.inv_i;
    assign inv_dcache_o     = cmd.inv_d;
    assign inv_dline_o      = cmd.line_inv;
    assign clean_dline_o    = cmd.line_clean;
    assign drain_wb_o       = cmd.drain;
    assign inv_itlb_o       = cmd.tlb_i;
    assign inv_dtlb_o       = cmd.tlb_d;
    assign inv_dtlb_entry_o = cmd.tlb_entry;
    assign rb_load_o        = cmd.rb_load;
    assign rb_inv_entry_o   = cmd.rb_inv_one;
    assign rb_inv_all_o     = cmd.rb_inv_all;
    assign op_err_o         = cmd.bad;

endmodule

// File: rtl/mmu_sysreg_checker.sv
// Assertion checker for the MMU system control register file, bound to the top.
module mmu_sysreg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_sel,
    input logic        wr_en,
    input logic [31:0] ctrl_o,
    input logic [31:0] ttb_o,
    input logic [31:0] dac_o,
    input logic [31:0] pid_o,
    input logic [10:0] cmds,
    input logic        op_err_o
);

    logic maint_wr;
    assign maint_wr = wr_en && (reg_sel == 4'd7 || reg_sel == 4'd8 || reg_sel == 4'd9);

    p_ctrl_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (ctrl_o[6:4] == 3'b111) && !ctrl_o[1] && (ctrl_o[31:16] == 16'h0));

    p_ttb_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (ttb_o[13:0] == 14'h0));

    p_pid_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((pid_o & 32'h81FF_FFFF) == 32'h0));

    p_err_alone_r12: assert property (@(posedge clk) disable iff (!rst_n)
        op_err_o |-> (cmds == 11'h0));

    p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cmds) || op_err_o) |-> $past(maint_wr));

    p_maint_keeps_regs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        maint_wr |=> $stable(ctrl_o) && $stable(ttb_o) && $stable(dac_o) && $stable(pid_o));

endmodule

bind mmu_sysreg_regfile mmu_sysreg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .ctrl_o   (ctrl_o),
    .ttb_o    (ttb_o),
    .dac_o    (dac_o),
    .pid_o    (pid_o),
    .cmds     ({inv_icache_o, inv_dcache_o, inv_dline_o, clean_dline_o, drain_wb_o,
                inv_itlb_o, inv_dtlb_o, inv_dtlb_entry_o, rb_load_o, rb_inv_entry_o,
                rb_inv_all_o}),
    .op_err_o (op_err_o)
);

// File: tb/mmu_sysreg_regfile_bench.sv
// Self-checking bench: sweeps every maintenance pair and register mask.
module mmu_sysreg_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  sub_op = '0;
    logic [3:0]  crm = '0;
    logic [31:0] rd_data, ctrl_o, ttb_o, dac_o, pid_o, maint_addr_o;
    logic        inv_icache_o, inv_dcache_o, inv_dline_o, clean_dline_o, drain_wb_o;
    logic        inv_itlb_o, inv_dtlb_o, inv_dtlb_entry_o, rb_load_o, rb_inv_entry_o;
    logic        rb_inv_all_o, op_err_o;
    logic [1:0]  rb_index_o, rb_type_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [31:0] mdl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_sysreg_regfile u_mmu_sysreg_regfile (.*);

    wire [11:0] got_cmd = {inv_icache_o, inv_dcache_o, inv_dline_o, clean_dline_o, drain_wb_o,
                           inv_itlb_o, inv_dtlb_o, inv_dtlb_entry_o, rb_load_o, rb_inv_entry_o,
                           rb_inv_all_o, op_err_o};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] masked(input logic [3:0] sel, input logic [31:0] d);
        case (sel)
            4'd1:  return (d | 32'h70) & 32'hFFFD;
            4'd2:  return d & 32'hFFFF_C000;
            4'd5:  return d & 32'hFF;
            4'd13: return d & 32'h7E00_0000;
            default: return d;
        endcase
    endfunction

    function automatic bit stored(input logic [3:0] sel);
        return sel == 1 || sel == 2 || sel == 3 || sel == 5 || sel == 6 || sel == 13;
    endfunction

    // expected {inv_i,inv_d,dline_inv,dline_clean,drain,itlb,dtlb,dtlb_entry,rb_load,rb_inv_one,rb_inv_all,err}
    function automatic logic [11:0] exp_cmd(input logic [3:0] sel, input logic [2:0] s, input logic [3:0] c);
        logic [11:0] e = '0;
        if (sel == 7) begin
            if (s == 0 && c == 7)       e = 12'b1100_0000_0000;
            else if (s == 0 && c == 5)  e = 12'b1000_0000_0000;
            else if (s == 0 && c == 6)  e = 12'b0100_0000_0000;
            else if (s == 1 && c == 6)  e = 12'b0010_0000_0000;
            else if (s == 1 && c == 10) e = 12'b0001_0000_0000;
            else if (s == 4 && c == 10) e = 12'b0000_1000_0000;
            else                        e = 12'b0000_0000_0001;
        end
        else if (sel == 8) begin
            if (s == 0 && c == 7)       e = 12'b0000_0110_0000;
            else if (s == 0 && c == 5)  e = 12'b0000_0100_0000;
            else if (s == 0 && c == 6)  e = 12'b0000_0010_0000;
            else if (s == 1 && c == 6)  e = 12'b0000_0001_0000;
            else                        e = 12'b0000_0000_0001;
        end
        else if (sel == 9) begin
            if (s == 0 && c == 0)       e = 12'b0000_0000_0010;
            else if (s == 2 && c < 12)  e = 12'b0000_0000_1000;
            else if (s == 1 && c < 4)   e = 12'b0000_0000_0100;
            else                        e = 12'b0000_0000_0001;
        end
        return e;
    endfunction

    // one write cycle; returns at the negedge after the sampling edge
    task automatic do_write(input logic [3:0] sel, input logic [2:0] s, input logic [3:0] c,
                            input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; sub_op = s; crm = c; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (stored(sel)) mdl[sel] = masked(sel, d);
    endtask

    task automatic check_reads(input string req);
        for (int k = 0; k < 16; k++) begin
            reg_sel = k[3:0];
            #1;
            check(req, rd_data, stored(k[3:0]) ? mdl[k] : 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6] = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A,
                                  32'h1234_5678, 32'h8000_0001};
        logic [3:0]  regs_l [6] = '{4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd13};
        for (int k = 0; k < 16; k++) mdl[k] = 32'h0;
        mdl[1] = 32'h70;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 ctrl_o", ctrl_o, 32'h70);
        check("R1 pid_o", pid_o, 32'h0);
        check("R1 pulses", {20'h0, got_cmd}, 32'h0);
        check_reads("R1/R2 reset reads");

        // R2..R5 masks over several patterns
        foreach (pats[p]) begin
            foreach (regs_l[r]) do_write(regs_l[r], 3'd0, 4'd0, pats[p] ^ {28'h0, regs_l[r]});
            check_reads("R2/R3/R4/R5 readback");
            check("R3 ctrl_o", ctrl_o, mdl[1]);
            check("R4 ttb_o", ttb_o, mdl[2]);
            check("R5 dac_o", dac_o, mdl[3]);
            check("R5 pid_o", pid_o, mdl[13]);
        end

        // R12 writes to unlisted numbers
        foreach (pats[p]) begin
            for (int s = 0; s < 16; s++) begin
                if (!stored(s[3:0]) && s != 7 && s != 8 && s != 9) begin
                    do_write(s[3:0], 3'd0, 4'd7, pats[p]);
                    check("R12 unlisted no pulse", {20'h0, got_cmd}, 32'h0);
                end
            end
        end
        check_reads("R12 unlisted no change");

        // R6..R12 full pair sweep
        for (int sel = 7; sel <= 9; sel++) begin
            for (int s = 0; s < 8; s++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [31:0] d;
                    logic [11:0] e;
                    d = {sel[3:0], s[3:0], c[3:0], 20'h0_3C5A} ^ 32'h0F0F_0000;
                    e = exp_cmd(sel[3:0], s[2:0], c[3:0]);
                    do_write(sel[3:0], s[2:0], c[3:0], d);
                    check("R6/R7/R8/R9/R10/R12 pulses", {20'h0, got_cmd}, {20'h0, e});
                    if (e[9] || e[8] || e[4] || e[3])
                        check("R7/R8/R9 maint_addr", maint_addr_o, d);
                    if (e[3]) begin
                        check("R9 rb_index", {30'h0, rb_index_o}, {30'h0, c[1:0]});
                        check("R9 rb_type", {30'h0, rb_type_o}, {30'h0, c[3:2] + 2'd1});
                    end
                    if (e[2])
                        check("R10 rb_index", {30'h0, rb_index_o}, {30'h0, c[1:0]});
                    check("R12 ctrl_o kept", ctrl_o, mdl[1]);
                    check("R12 ttb_o kept", ttb_o, mdl[2]);
                    @(negedge clk);
                    check("R11 pulse width", {20'h0, got_cmd}, 32'h0);
                end
            end
            check_reads("R12 maint no change");
        end

        // R11 pulse overlapping a following control write
        @(negedge clk);
        reg_sel = 4'd7; sub_op = 3'd0; crm = 4'd7; wr_data = 32'h0; wr_en = 1'b1;
        @(negedge clk);
        reg_sel = 4'd1; wr_data = 32'hFFFF_0002;
        check("R11 pulse during next write", {20'h0, got_cmd}, 32'hC00);
        check("R11 ctrl before write", ctrl_o, mdl[1]);
        @(negedge clk);
        wr_en = 1'b0;
        mdl[1] = masked(4'd1, 32'hFFFF_0002);
        check("R11 pulse gone", {20'h0, got_cmd}, 32'h0);
        check("R3 ctrl after overlap", ctrl_o, 32'h0000_0070);

        // R1 reset again after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 ctrl after reset", ctrl_o, 32'h70);
        check("R1 ttb after reset", ttb_o, 32'h0);
        check("R1 pid after reset", pid_o, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule